// File: doc/BRIEF.md
# I2C Event Interrupt Vector Unit

This block sits beside an I2C controller core and turns its single-cycle event pulses into latched flags. A mask register selects which flags may raise the interrupt line, and a vector register returns a small code that names the most urgent pending, enabled event. Software services the interrupt by reading the vector until it reads zero. Each read of the vector retires the event it names.

Register access uses a single request port. `addr_i` selects the mask (0), the status view (1) or the vector (2). A read returns data on `rdata_o` one clock after the request, and `rdata_o` holds that value until the next read. Three of the flags can also be cleared by writing ones to the status view. Two level inputs, receive-shift-full and bus-busy, are shown in the status view only.

Top module: `i2civ_top`

## Requirements
- R1: After reset all flags and the mask are zero, `rdata_o` is 0 and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets flag k. The bit positions are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as target. The status view shows flag k at bit k.
- R3: Status view bit 11 reflects `rx_full_i` and bit 12 reflects `bus_busy_i` at the read. Bits 7–10 and 13–15 read 0.
- R4: A status write clears flags 2, 3 and 5 wherever the written bit is 1. Written zeros have no effect, and ones at bits 0, 1, 4 and 6 have no effect.
- R5: The mask uses bits 0–6 with the same positions as R2 and is readable and writable. Its upper bits read 0.
- R6: A vector read returns k+1 for the lowest-indexed flag k that is both set and enabled. The codes are: 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed as target.
- R7: A vector read returns 0 when no enabled flag is set. A flag whose mask bit is clear stays set but is never reported.
- R8: A vector read that returns a non-zero code clears that flag, so the next read reports the next pending event.
- R9: `irq_o` is high exactly when some flag is set with its mask bit set.
- R10: A pulse that arrives in the same cycle as a clear of the same flag leaves the flag set.
- R11: `rx_full_i` and `bus_busy_i` never produce a vector code and never raise `irq_o`.
- R12: A write to the vector address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | 0 = mask, 1 = status, 2 = vector |
| wdata_i | input | 16 | Write data |
| evt_i | input | 7 | Event pulses from the controller core |
| rx_full_i | input | 1 | Receive shift register full (status only) |
| bus_busy_i | input | 1 | Bus busy (status only) |
| rdata_o | output | 16 | Read data, registered |
| irq_o | output | 1 | Level interrupt request |

## Verification
An event pulse presented before a clock edge shows up in the flags, in `irq_o` and in the following status or vector read after that same edge. Read data appears on `rdata_o` one edge after the request, and a read-clear or write-clear takes effect at that same edge. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and the bench compares `rdata_o` and `irq_o` with the model on every falling edge. Directed checks sample the value one full cycle after each request was issued.

// File: rtl/i2civ_pkg.sv
package i2civ_pkg;
  localparam int EVT_N    = 7;
  localparam int CODE_W   = $clog2(EVT_N + 1);
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 2;
  localparam int RXF_BIT  = 11;
  localparam int BUSY_BIT = 12;
  // flags that a status write may clear: access ready, receive ready, stop
  localparam logic [EVT_N-1:0] W1C_EVT = 7'b010_1100;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VEC  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/i2civ_flags.sv
module i2civ_flags
  import i2civ_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] set_i,
  input  logic [EVT_N-1:0] clr_i,
  output logic [EVT_N-1:0] flags_o
);
  // a new event wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/i2civ_prio.sv
module i2civ_prio
  import i2civ_pkg::*;
(
  input  logic [EVT_N-1:0]  pend_i,
  output logic [CODE_W-1:0] code_o
);
  logic [EVT_N-1:0] hit;

  // hit[g]: pend[g] set and nothing of higher priority pending
  for (genvar g = 0; g < EVT_N; g++) begin : g_hit
    if (g == 0) begin : g_first
      assign hit[g] = pend_i[g];
    end else begin : g_rest
      assign hit[g] = pend_i[g] & ~|pend_i[g-1:0];
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < EVT_N; i++)
      if (hit[i]) code_o = code_o | CODE_W'(i + 1);
  end
endmodule

// File: rtl/i2civ_regif.sv
module i2civ_regif
  import i2civ_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [EVT_N-1:0]  flags_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rx_full_i,
  input  logic              bus_busy_i,
  output logic [EVT_N-1:0]  mask_o,
  output logic [EVT_N-1:0]  clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic             wr, rd;
  logic [REG_W-1:0] stat_view, rd_mux;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mask_o <= '0;
    else if (wr && addr_i == SEL_MASK) mask_o <= wdata_i[EVT_N-1:0];
  end

  always_comb begin
    stat_view              = '0;
    stat_view[EVT_N-1:0]   = flags_i;
    stat_view[RXF_BIT]     = rx_full_i;
    stat_view[BUSY_BIT]    = bus_busy_i;
  end

  always_comb begin
    unique case (addr_i)
      SEL_MASK: rd_mux = REG_W'(mask_o);
      SEL_STAT: rd_mux = stat_view;
      SEL_VEC:  rd_mux = REG_W'(code_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) rdata_o <= rd_mux;
  end

  // clear sources: status write-one-to-clear, vector read retires reported flag
  always_comb begin
    clr_o = '0;
    if (wr && addr_i == SEL_STAT)
      clr_o = wdata_i[EVT_N-1:0] & W1C_EVT;
    else if (rd && addr_i == SEL_VEC && code_i != '0)
      clr_o = EVT_N'(1) << (code_i - CODE_W'(1));
  end
endmodule

// File: rtl/i2civ_top.sv
module i2civ_top
  import i2civ_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              rx_full_i,
  input  logic              bus_busy_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [EVT_N-1:0]  flags_q, mask_q, clr, pend;
  logic [CODE_W-1:0] code;

  i2civ_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_i),
    .clr_i   (clr),
    .flags_o (flags_q)
  );

  assign pend  = flags_q & mask_q;
  assign irq_o = |pend;

  i2civ_prio u_prio (
    .pend_i (pend),
    .code_o (code)
  );

  i2civ_regif u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .flags_i    (flags_q),
    .code_i     (code),
    .rx_full_i  (rx_full_i),
    .bus_busy_i (bus_busy_i),
    .mask_o     (mask_q),
    .clr_o      (clr),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/i2civ_chk.sv
module i2civ_chk
  import i2civ_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [EVT_N-1:0]  evt_i,
  input logic [EVT_N-1:0]  flags,
  input logic [EVT_N-1:0]  mask,
  input logic [CODE_W-1:0] code,
  input logic              irq_o
);
  assert_irq_vs_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code != '0) == irq_o);

  assert_code_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code != '0) |-> (flags[code - CODE_W'(1)] && mask[code - CODE_W'(1)]));

  assert_code_lowest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code != '0) |->
      ((flags & mask & ((EVT_N'(1) << (code - CODE_W'(1))) - EVT_N'(1))) == '0));

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  assert_w1c_scope_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == SEL_STAT) |=>
      (($past(flags) & ~W1C_EVT & ~flags) == '0));

  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == SEL_MASK) |=> $stable(mask));

  assert_vec_retire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == SEL_VEC && code != '0 && !evt_i[code - CODE_W'(1)])
      |=> !flags[$past(code) - CODE_W'(1)]);

  assert_vec_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == SEL_VEC && evt_i == '0) |=>
      ($stable(flags) && $stable(mask)));
endmodule

bind i2civ_top i2civ_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .evt_i  (evt_i),
  .flags  (flags_q),
  .mask   (mask_q),
  .code   (code),
  .irq_o  (irq_o)
);

// File: tb/i2civ_top_test.sv
module i2civ_top_test;
  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [6:0]  evt = 7'd0;
  logic        rxf = 1'b0, bsy = 1'b0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  i2civ_top uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .evt_i(evt), .rx_full_i(rxf), .bus_busy_i(bsy),
    .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [6:0]  m_fl, m_mk, m_cl;
  logic [15:0] m_rd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fl = 0; m_mk = 0; m_rd = 0;
    end else begin
      m_cl = 0;
      if (req && we && addr == 2'd0) m_mk = wdata[6:0];
      if (req && we && addr == 2'd1) m_cl = wdata[6:0] & 7'h2C;
      if (req && !we) begin
        case (addr)
          2'd0: m_rd = {9'd0, m_mk};
          2'd1: m_rd = {3'd0, bsy, rxf, 4'd0, m_fl};
          2'd2: begin
            m_rd = 0;
            for (int i = 6; i >= 0; i--) if (m_fl[i] && m_mk[i]) m_rd = 16'(i + 1);
            if (m_rd != 0) m_cl[m_rd - 1] = 1'b1;
          end
          default: m_rd = 0;
        endcase
      end
      m_fl = (m_fl & ~m_cl) | evt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 model irq", 32'(irq), 32'(|(m_fl & m_mk)));
      chk("R6 model rdata", 32'(rdata), 32'(m_rd));
    end
  end

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [6:0] e);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; evt = e;
    @(negedge clk); req = 0; we = 0; evt = 0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", 32'(rdata), 0);
    chk("R1 reset irq", 32'(irq), 0);
    rst_n = 1;
    rd(2'd0, v); chk("R1 mask after reset", 32'(v), 0);
    rd(2'd1, v); chk("R1 status after reset", 32'(v), 0);

    pulse(7'h01);
    rd(2'd1, v); chk("R2 status bit0 set", 32'(v), 32'h0001);
    chk("R9 irq low while masked", 32'(irq), 0);
    rd(2'd2, v); chk("R7 vector 0 while masked", 32'(v), 0);

    wr(2'd0, 16'hFFFF, 0);
    rd(2'd0, v); chk("R5 mask upper bits read 0", 32'(v), 32'h007F);
    chk("R9 irq high once enabled", 32'(irq), 1);

    pulse(7'h32);
    rd(2'd2, v); chk("R6 vector arb lost", 32'(v), 1);
    rd(2'd2, v); chk("R8 next vector no-ack", 32'(v), 2);
    rd(2'd2, v); chk("R8 next vector tx ready", 32'(v), 5);
    rd(2'd2, v); chk("R8 next vector stop", 32'(v), 6);
    rd(2'd2, v); chk("R7 vector empty", 32'(v), 0);
    chk("R9 irq low when drained", 32'(irq), 0);

    pulse(7'h7F);
    wr(2'd1, 16'h007F, 0);
    rd(2'd1, v); chk("R4 only bits 2,3,5 cleared", 32'(v), 32'h0053);
    wr(2'd1, 16'h0000, 0);
    rd(2'd1, v); chk("R4 zero write no effect", 32'(v), 32'h0053);

    wr(2'd0, 16'h006F, 0);
    rd(2'd2, v); chk("R6 vector 1 with tx masked", 32'(v), 1);
    rd(2'd2, v); chk("R6 vector 2 with tx masked", 32'(v), 2);
    rd(2'd2, v); chk("R7 skips masked tx ready", 32'(v), 7);
    rd(2'd2, v); chk("R7 masked flag not reported", 32'(v), 0);
    rd(2'd1, v); chk("R7 masked flag still set", 32'(v), 32'h0010);
    chk("R9 irq low with only masked flag", 32'(irq), 0);
    wr(2'd0, 16'h007F, 0);
    chk("R9 irq high on unmask", 32'(irq), 1);
    rd(2'd2, v); chk("R7 tx ready reported after unmask", 32'(v), 5);

    @(negedge clk); rxf = 1; bsy = 1;
    rd(2'd1, v); chk("R3 rx full and busy bits", 32'(v), 32'h1800);
    rd(2'd2, v); chk("R11 vector ignores status-only inputs", 32'(v), 0);
    chk("R11 irq ignores status-only inputs", 32'(irq), 0);
    @(negedge clk); rxf = 0; bsy = 0;

    pulse(7'h04);
    wr(2'd1, 16'h0004, 7'h04);
    rd(2'd1, v); chk("R10 event beats clear", 32'(v), 32'h0004);
    wr(2'd2, 16'hFFFF, 0);
    rd(2'd0, v); chk("R12 mask kept after vector write", 32'(v), 32'h007F);
    rd(2'd2, v); chk("R12 vector write ignored", 32'(v), 3);
    pulse(7'h20);
    wr(2'd1, 16'h0020, 0);
    rd(2'd1, v); chk("R4 stop flag cleared by write", 32'(v), 0);

    pulse(7'h7F);
    for (int k = 1; k <= 7; k++) begin
      rd(2'd2, v); chk("R6 full priority order", 32'(v), 32'(k));
    end
    rd(2'd2, v); chk("R8 all retired", 32'(v), 0);

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule